// File: doc/BRIEF.md
# Asymmetric Input Deglitcher Bank

This block sits between raw comparator decisions and a supply sequencer. The comparators have no hysteresis, so their outputs chatter and carry short spikes. Each raw bit is first brought into the clock domain through a two-flop synchronizer. A per-channel counter then lets the filtered output take a new level only after the synchronized input has held that level for a set number of clock cycles. If the input returns to the current filtered level before that count is reached, the counter starts again from zero.

The inputs fall into three classes, and each class has its own pair of qualification times: one for a low-to-high change and one for a high-to-low change. The classes are the rail monitors, the sequencing control inputs and a single shared fault input. The rail monitors are strongly asymmetric. A rail must read good for several times longer than it must read bad before the filtered view changes. This makes a power-good decision slow to assert and quick to drop. The sequencer reads only the filtered bits.

Top module: `glitch_filter_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, every filtered output reads 0. For the monitors this means not good, for the controls it means low, and for the fault output it means deasserted.
- R2: A monitor input that goes high and stays high gives a high filtered output on exactly the MON_RISE_CYC+2-th rising clock edge. The first edge counted is the first one that samples the new level.
- R3: A monitor input that goes low and stays low gives a low filtered output on exactly the MON_FALL_CYC+2-th rising edge. The first edge counted is the first one that samples the new level.
- R4: A control input changes its filtered output on the CTL_RISE_CYC+2-th edge when it goes high and on the CTL_FALL_CYC+2-th edge when it goes low.
- R5: The fault input changes its filtered output on the FLT_RISE_CYC+2-th edge when it goes high and on the FLT_FALL_CYC+2-th edge when it goes low.
- R6: An excursion away from the filtered level that lasts fewer cycles than the qualification time for that direction leaves the filtered output unchanged. This holds for both a high spike on a low output and a low dip on a high output.
- R7: When the input returns to the filtered level, the qualification count restarts from zero. A later excursion then needs the full qualification time, however long the earlier excursions lasted.
- R8: Each channel is filtered on its own. Activity on one input never changes the filtered output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_raw | input | NUM_MON | Raw rail comparator decisions, 1 = above threshold |
| ctl_raw | input | NUM_CTL | Raw sequencing control comparator decisions |
| flt_raw | input | 1 | Raw shared fault input, 1 = fault present |
| mon_q | output | NUM_MON | Filtered rail monitor levels |
| ctl_q | output | NUM_CTL | Filtered control levels |
| flt_q | output | 1 | Filtered fault level |

## Verification
The block has little internal state, and all of it shows at the ports within one qualification window. There are the two synchronizer stages, the run counter and the filtered flop. A counter that fails to clear on a return to the filtered level makes a later excursion qualify early, and the output then moves before the exact edge given for that direction. A counter that selects the wrong limit shows up as a change delayed or advanced by the difference between the rise time and the fall time. A lost or extra synchronizer stage shifts every transition by one cycle. A cycle-by-cycle model catches each of these faults on the first transition that follows.

// File: rtl/gf_pkg.sv
package gf_pkg;
   // Input classes handled by the bank; used to pick timing at elaboration.
   typedef enum logic [1:0] {
      GF_MONITOR = 2'd0,
      GF_CONTROL = 2'd1,
      GF_FAULT   = 2'd2
   } gf_class_e;

   function automatic int gf_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Counter width able to hold values up to lim-1, never below one bit.
   function automatic int gf_cnt_width(input int lim);
      return (lim < 2) ? 1 : $clog2(lim);
   endfunction
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= RST_VAL;
         q    <= RST_VAL;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/gf_qualify.sv
module gf_qualify
   import gf_pkg::*;
#(
   parameter int   RISE_CYC = 4,
   parameter int   FALL_CYC = 4,
   parameter logic RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   output logic q
);
   localparam int MAX_LIM = gf_max(RISE_CYC, FALL_CYC);
   localparam int MIN_LIM = (RISE_CYC < FALL_CYC) ? RISE_CYC : FALL_CYC;
   localparam int CW      = gf_cnt_width(MAX_LIM);
   localparam logic [CW-1:0] RISE_TOP = CW'(RISE_CYC - 1);
   localparam logic [CW-1:0] FALL_TOP = CW'(FALL_CYC - 1);

   if (RISE_CYC < 1 || FALL_CYC < 1) begin : g_bad_lim
      $error("gf_qualify: qualification times must be at least one cycle");
   end

   logic [CW-1:0] run;
   logic [CW-1:0] top;

   // Waiting to leave a high level uses the fall time, and the reverse.
   assign top = q ? FALL_TOP : RISE_TOP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= RST_VAL;
         run <= '0;
      end else if (s == q) begin
         run <= '0;
      end else if (run == top) begin
         q   <= s;
         run <= '0;
      end else begin
         run <= run + 1'b1;
      end
   end

   // R6: the run counter stays inside the longer qualification window.
   a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run <= CW'(MAX_LIM - 1));

   // R7: an input agreeing with the output freezes the output next cycle.
   a_r7_hold_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (s == q) |=> $stable(q));

   // R2: a change in the output always moves towards the synchronized level.
   a_r2_moves_to_input: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> (q == $past(s)));

   if (MIN_LIM > 1) begin : g_spacing
      // R6: with multi-cycle windows two output changes are never adjacent.
      a_r6_no_adjacent_toggle: assert property (@(posedge clk) disable iff (!rst_n)
         (q != $past(q)) |=> $stable(q));
   end
endmodule

// File: rtl/gf_class.sv
module gf_class
   import gf_pkg::*;
#(
   parameter int        WIDTH    = 1,
   parameter gf_class_e KIND     = GF_MONITOR,
   parameter int        RISE_CYC = 4,
   parameter int        FALL_CYC = 4,
   parameter logic      RST_VAL  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] filt
);
   if (WIDTH < 1) begin : g_bad_width
      $error("gf_class: class %0d needs at least one channel", KIND);
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_ch
      logic s;

      gf_sync #(.RST_VAL(RST_VAL)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw[i]),
         .q     (s)
      );

      gf_qualify #(
         .RISE_CYC (RISE_CYC),
         .FALL_CYC (FALL_CYC),
         .RST_VAL  (RST_VAL)
      ) i_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .s     (s),
         .q     (filt[i])
      );
   end
endmodule

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank
   import gf_pkg::*;
#(
   parameter int NUM_MON      = 4,
   parameter int NUM_CTL      = 2,
   parameter int MON_RISE_CYC = 2660,
   parameter int MON_FALL_CYC = 470,
   parameter int CTL_RISE_CYC = 680,
   parameter int CTL_FALL_CYC = 680,
   parameter int FLT_RISE_CYC = 560,
   parameter int FLT_FALL_CYC = 560
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_MON-1:0] mon_raw,
   input  logic [NUM_CTL-1:0] ctl_raw,
   input  logic               flt_raw,
   output logic [NUM_MON-1:0] mon_q,
   output logic [NUM_CTL-1:0] ctl_q,
   output logic               flt_q
);
   if (MON_RISE_CYC <= MON_FALL_CYC) begin : g_mon_skew
      $warning("glitch_filter_bank: monitor rise window is not longer than fall window");
   end

   gf_class #(
      .WIDTH(NUM_MON), .KIND(GF_MONITOR),
      .RISE_CYC(MON_RISE_CYC), .FALL_CYC(MON_FALL_CYC), .RST_VAL(1'b0)
   ) i_mon (
      .clk(clk), .rst_n(rst_n), .raw(mon_raw), .filt(mon_q)
   );

   gf_class #(
      .WIDTH(NUM_CTL), .KIND(GF_CONTROL),
      .RISE_CYC(CTL_RISE_CYC), .FALL_CYC(CTL_FALL_CYC), .RST_VAL(1'b0)
   ) i_ctl (
      .clk(clk), .rst_n(rst_n), .raw(ctl_raw), .filt(ctl_q)
   );

   gf_class #(
      .WIDTH(1), .KIND(GF_FAULT),
      .RISE_CYC(FLT_RISE_CYC), .FALL_CYC(FLT_FALL_CYC), .RST_VAL(1'b0)
   ) i_flt (
      .clk(clk), .rst_n(rst_n), .raw(flt_raw), .filt(flt_q)
   );

   // R1: first active cycle after reset still shows the reset levels.
   a_r1_reset_levels: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mon_q == '0 && ctl_q == '0 && !flt_q));
endmodule

// File: tb/test_glitch_filter_bank.sv
module test_glitch_filter_bank;
   localparam int NM = 4;
   localparam int NC = 2;
   localparam int N  = NM + NC + 1;
   localparam int MR = 20, MF = 4, CR = 6, CF = 7, FR = 5, FF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] raw_v = '0;
   logic [NM-1:0] mon_q;
   logic [NC-1:0] ctl_q;
   logic flt_q;
   logic [N-1:0] out_v;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   glitch_filter_bank #(
      .NUM_MON(NM), .NUM_CTL(NC),
      .MON_RISE_CYC(MR), .MON_FALL_CYC(MF),
      .CTL_RISE_CYC(CR), .CTL_FALL_CYC(CF),
      .FLT_RISE_CYC(FR), .FLT_FALL_CYC(FF)
   ) i_glitch_filter_bank (
      .clk(clk), .rst_n(rst_n),
      .mon_raw(raw_v[NM-1:0]), .ctl_raw(raw_v[NM+NC-1:NM]), .flt_raw(raw_v[N-1]),
      .mon_q(mon_q), .ctl_q(ctl_q), .flt_q(flt_q)
   );

   assign out_v = {flt_q, ctl_q, mon_q};

   function automatic int lim_of(int idx, bit going_high);
      if (idx < NM)      return going_high ? MR : MF;
      if (idx < NM + NC) return going_high ? CR : CF;
      return going_high ? FR : FF;
   endfunction

   function automatic string tag_of(int idx, bit going_high);
      if (idx < NM)      return going_high ? "R2" : "R3";
      if (idx < NM + NC) return "R4";
      return "R5";
   endfunction

   task automatic check(string tag, int actual, int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, actual, expected, $time);
      end
   endtask

   // Behavioural reference: a queue delays each input by two edges, and an
   // integer counts how long the delayed level has disagreed with the output.
   bit mq[N];
   int stay[N];
   bit dly[N][$];

   always @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!rst_n) begin
            mq[i] = 1'b0;
            stay[i] = 0;
            dly[i] = {1'b0, 1'b0};
         end else begin
            bit seen;
            seen = dly[i][0];
            if (seen == mq[i]) stay[i] = 0;
            else begin
               stay[i]++;
               if (stay[i] >= lim_of(i, seen)) begin
                  mq[i] = seen;
                  stay[i] = 0;
               end
            end
            void'(dly[i].pop_front());
            dly[i].push_back(raw_v[i]);
         end
      end
   end

   // R8: every channel is compared against its own model on every cycle.
   always @(negedge clk) begin
      if (model_on) begin
         for (int i = 0; i < N; i++)
            if (out_v[i] !== mq[i])
               check($sformatf("%s R8 ch%0d", tag_of(i, mq[i]), i), out_v[i], mq[i]);
            else checks++;
      end
   end

   // Drive one input to a new level and check the exact edge it appears on.
   task automatic latency(int idx, bit val);
      int n;
      n = lim_of(idx, val) + 2;
      raw_v[idx] = val;
      repeat (n - 1) @(negedge clk);
      check({tag_of(idx, val), " before window"}, out_v[idx], !val);
      @(negedge clk);
      check({tag_of(idx, val), " at window"}, out_v[idx], val);
   endtask

   task automatic pulse(int idx, bit val, int len);
      raw_v[idx] = val;
      repeat (len) @(negedge clk);
      raw_v[idx] = !val;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      check("R1 in reset", int'(out_v), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", int'(out_v), 0);
      model_on = 1'b1;

      latency(0, 1'b1);                 // R2
      latency(0, 1'b0);                 // R3
      latency(NM + 1, 1'b1);            // R4 rise
      latency(NM + 1, 1'b0);            // R4 fall
      latency(N - 1, 1'b1);             // R5 rise
      latency(N - 1, 1'b0);             // R5 fall

      // R6: high spike one short of the rise window on a low monitor.
      pulse(1, 1'b1, MR - 1);
      repeat (MR + 6) @(negedge clk);
      check("R6 high spike ignored", out_v[1], 0);
      // R6: low dip one short of the fall window on a high monitor.
      latency(2, 1'b1);
      pulse(2, 1'b0, MF - 1);
      repeat (MF + 6) @(negedge clk);
      check("R6 low dip ignored", out_v[2], 1);

      // R7: near-complete excursions broken by single returns, then full wait.
      pulse(3, 1'b1, MR - 1);
      @(negedge clk);
      pulse(3, 1'b1, MR - 2);
      @(negedge clk);
      check("R7 still low after interrupted runs", out_v[3], 0);
      latency(3, 1'b1);

      // R8: mixed activity on all channels, model compared every cycle.
      lfsr = 16'hACE1;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[2:0] == 3'd0) raw_v[lfsr[6:4] % N] = lfsr[9];
      end
      raw_v = '0;
      repeat (MR + 10) @(negedge clk);
      check("R8 all settle low", int'(out_v), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule